// File: doc/BRIEF.md
# Rate One-Half Convolutional Encoder

This block turns a serial message into a rate one-half convolutional code. It has a memory depth of two and four states. The encoder keeps the two most recent message bits in a shift register. Each time it takes a new message bit, it combines that bit with the stored ones through two XOR tap sets and produces a pair of coded bits. The pair is presented on parallel outputs for one cycle. The same two bits are also streamed out one per clock, first tap set first.

Because the serial stream needs two clocks per message bit, the encoder accepts a new bit at most every second cycle. It uses a ready signal to hold the source off in between. A flush request terminates the trellis. The encoder injects as many zero bits as it has memory stages, so the register ends in the all-zero state. The last coded pair of the frame carries an end-of-frame flag. Tap masks and memory depth are parameters. The defaults give the four-state code with taps 111 and 101.

Top module: `conv_enc_half`

## Requirements
- R1: After reset the shift register holds zeros, `in_ready` is 1, and `pair_valid`, `ser_valid`, `pair_eof` and `ser_eof` are 0. Nothing is valid until the first accepted bit or flush.
- R2: For message bit m(j), with m(j-1) and m(j-2) the two previously accepted bits, `pair_a` = m(j) XOR m(j-1) XOR m(j-2).
- R3: `pair_b` = m(j) XOR m(j-2) for the same bit.
- R4: A bit is accepted on a rising edge where `in_ready` and `in_valid` are both 1. `pair_valid` is 1 for exactly the cycle after that edge, and the pair outputs hold that bit's code.
- R5: The serial stream shows `pair_a` in the cycle after acceptance and `pair_b` in the cycle after that, with `ser_valid` 1 in both. When no pair is pending, `ser_valid` is 0.
- R6: `in_ready` is 0 in the cycle after each acceptance and 1 again in the following cycle, unless a flush tail is running. Back-to-back bits therefore produce a gap-free serial stream.
- R7: A flush accepted while `in_ready` is 1 encodes two zero bits in successive two-cycle slots. `in_ready` stays 0 for three cycles after the flush edge. `pair_eof`, and `ser_eof` on the second serial bit, are 1 only for the last tail pair.
- R8: After a flush the register is all-zero, so the next frame encodes exactly as it would after reset.
- R9: When `flush` and `in_valid` are both 1 on an accepting edge, the flush wins and `in_bit` is ignored.
- R10: `in_valid` asserted while `in_ready` is 0 has no effect: no bit is consumed and the coded stream is unchanged.
- R11: A single 1 followed by zeros, from the zero state, yields pairs 11, 10, 11 and then 00. Each message bit affects exactly six coded bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Message bit offered |
| in_bit | input | 1 | Message bit value |
| flush | input | 1 | Request trellis termination with zero tail |
| in_ready | output | 1 | Encoder can take a bit or a flush this cycle |
| pair_valid | output | 1 | Coded pair valid, one-cycle pulse |
| pair_a | output | 1 | Coded bit from the first tap set |
| pair_b | output | 1 | Coded bit from the second tap set |
| pair_eof | output | 1 | Pair is the last of a terminated frame |
| ser_valid | output | 1 | Serial coded bit valid |
| ser_bit | output | 1 | Serial coded bit, first tap set first |
| ser_eof | output | 1 | Serial bit is the final bit of a frame |

## Verification
The bench builds the encoder with its default parameters: memory depth two and taps 111 and 101. With these values all four states are reachable within a few bits, and the impulse response can be written down by hand. The tail is exactly two slots long, so the three-cycle ready gap after a flush is a fixed, countable window. A reference model in the bench tracks the two previous bits and predicts every pair. It also predicts the ordering of the serial stream while bits are streamed back to back, with idle gaps, with stray valid requests during busy cycles, and with flushes that collide with data.

// File: rtl/conv_enc_pkg.sv
`timescale 1ns/1ps
package conv_enc_pkg;
  localparam int unsigned WIN_MAX = 32;

  // Parity of a masked window; bit 0 of the window is the newest bit.
  function automatic logic tap_xor(input logic [WIN_MAX-1:0] win,
                                   input logic [WIN_MAX-1:0] mask);
    return ^(win & mask);
  endfunction
endpackage

// File: rtl/conv_shift.sv
`timescale 1ns/1ps
module conv_shift #(
  parameter int unsigned MEM = 2,
  parameter logic [MEM:0] TAP_A = 3'b111,
  parameter logic [MEM:0] TAP_B = 3'b101
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic           din,
  output logic           code_a,
  output logic           code_b,
  output logic [MEM-1:0] state
);
  import conv_enc_pkg::*;

  logic [MEM:0] win;

  assign win    = {state, din};
  assign code_a = tap_xor(WIN_MAX'(win), WIN_MAX'(TAP_A));
  assign code_b = tap_xor(WIN_MAX'(win), WIN_MAX'(TAP_B));

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= '0;
    else if (step) state <= win[MEM-1:0];
  end

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> state[0] == $past(din)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state)); // R10
endmodule

// File: rtl/conv_term.sv
`timescale 1ns/1ps
module conv_term #(
  parameter int unsigned MEM = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_free,
  input  logic flush_go,
  output logic tail_active,
  output logic tail_step,
  output logic last_step
);
  localparam int unsigned CW = $clog2(MEM + 1);
  localparam logic [CW-1:0] TAIL_INIT = CW'(MEM - 1);
  localparam bit ONE_TAIL = (MEM == 1);

  logic [CW-1:0] tail_left;

  assign tail_active = (tail_left != '0);
  assign tail_step   = slot_free && tail_active;
  assign last_step   = (flush_go && ONE_TAIL) ||
                       (tail_step && tail_left == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                      tail_left <= '0;
    else if (flush_go && !ONE_TAIL)  tail_left <= TAIL_INIT;
    else if (tail_step)              tail_left <= tail_left - CW'(1);
  end

  AST_TAIL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tail_left <= TAIL_INIT); // R7
  AST_TAIL_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_step && tail_left == CW'(1)) |=> !tail_active); // R7
endmodule

// File: rtl/conv_ser.sv
`timescale 1ns/1ps
module conv_ser (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic a_in,
  input  logic b_in,
  input  logic eof_in,
  output logic ser_valid,
  output logic ser_bit,
  output logic ser_eof,
  output logic slot_free
);
  logic half_q;
  logic hold_bit_q;
  logic hold_eof_q;

  // A new pair may load while the second bit of the previous one shows.
  assign slot_free = !ser_valid || half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_valid  <= 1'b0;
      ser_bit    <= 1'b0;
      ser_eof    <= 1'b0;
      half_q     <= 1'b0;
      hold_bit_q <= 1'b0;
      hold_eof_q <= 1'b0;
    end else if (load) begin
      ser_valid  <= 1'b1;
      ser_bit    <= a_in;
      ser_eof    <= 1'b0;
      half_q     <= 1'b0;
      hold_bit_q <= b_in;
      hold_eof_q <= eof_in;
    end else if (ser_valid && !half_q) begin
      ser_bit <= hold_bit_q;
      ser_eof <= hold_eof_q;
      half_q  <= 1'b1;
    end else begin
      ser_valid <= 1'b0;
      ser_eof   <= 1'b0;
      half_q    <= 1'b0;
    end
  end

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> slot_free); // R6
  AST_SECOND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && !half_q) |=> (ser_valid && half_q)); // R5
endmodule

// File: rtl/conv_enc_half.sv
`timescale 1ns/1ps
module conv_enc_half #(
  parameter int unsigned MEM = 2,
  parameter logic [MEM:0] TAP_A = 3'b111,
  parameter logic [MEM:0] TAP_B = 3'b101
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  input  logic flush,
  output logic in_ready,
  output logic pair_valid,
  output logic pair_a,
  output logic pair_b,
  output logic pair_eof,
  output logic ser_valid,
  output logic ser_bit,
  output logic ser_eof
);
  logic           slot_free;
  logic           tail_active;
  logic           tail_step;
  logic           last_step;
  logic           data_go;
  logic           flush_go;
  logic           step;
  logic           din;
  logic           code_a;
  logic           code_b;
  logic [MEM-1:0] state;

  assign in_ready = slot_free && !tail_active;
  assign flush_go = in_ready && flush;
  assign data_go  = in_ready && in_valid && !flush;
  assign step     = data_go || flush_go || tail_step;
  assign din      = data_go ? in_bit : 1'b0;

  conv_shift #(.MEM(MEM), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_shift (
    .clk(clk), .rst_n(rst_n), .step(step), .din(din),
    .code_a(code_a), .code_b(code_b), .state(state)
  );

  conv_term #(.MEM(MEM)) u_term (
    .clk(clk), .rst_n(rst_n), .slot_free(slot_free), .flush_go(flush_go),
    .tail_active(tail_active), .tail_step(tail_step), .last_step(last_step)
  );

  conv_ser u_ser (
    .clk(clk), .rst_n(rst_n), .load(step), .a_in(code_a), .b_in(code_b),
    .eof_in(last_step), .ser_valid(ser_valid), .ser_bit(ser_bit),
    .ser_eof(ser_eof), .slot_free(slot_free)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_valid <= 1'b0;
      pair_a     <= 1'b0;
      pair_b     <= 1'b0;
      pair_eof   <= 1'b0;
    end else begin
      pair_valid <= step;
      if (step) begin
        pair_a   <= code_a;
        pair_b   <= code_b;
        pair_eof <= last_step;
      end
    end
  end

  AST_PAIR_SER_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (ser_valid && ser_bit == pair_a && !ser_eof)); // R5
  AST_PAIR_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid); // R6
  AST_EOF_ZERO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_eof) |-> (state == '0)); // R8
  AST_READY_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !in_ready); // R6
endmodule

// File: tb/tb_conv_enc_half.sv
`timescale 1ns/1ps
module tb_conv_enc_half;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic flush = 1'b0;
  logic in_ready, pair_valid, pair_a, pair_b, pair_eof;
  logic ser_valid, ser_bit, ser_eof;

  conv_enc_half dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .flush(flush), .in_ready(in_ready), .pair_valid(pair_valid),
    .pair_a(pair_a), .pair_b(pair_b), .pair_eof(pair_eof),
    .ser_valid(ser_valid), .ser_bit(ser_bit), .ser_eof(ser_eof)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model: the two previously accepted bits.
  bit m1 = 1'b0;
  bit m2 = 1'b0;
  bit qa[$];
  bit qb[$];
  bit qe[$];
  string ql[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(input bit b, input bit eof, input string lbl);
    qa.push_back(b ^ m1 ^ m2);
    qb.push_back(b ^ m2);
    qe.push_back(eof);
    ql.push_back(lbl);
    m2 = m1;
    m1 = b;
  endtask

  // Monitor: pops predicted pairs and follows the serial stream.
  bit pend = 1'b0;
  bit pend_bit = 1'b0;
  bit pend_eof = 1'b0;
  string pend_lbl = "";
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pend) begin
        chk(ser_valid == 1'b1, "R5", {pend_lbl, " second serial bit valid"}, int'(ser_valid), 1);
        chk(ser_bit == pend_bit, "R5", {pend_lbl, " second serial bit value"}, int'(ser_bit), int'(pend_bit));
        chk(ser_eof == pend_eof, "R7", {pend_lbl, " serial end flag"}, int'(ser_eof), int'(pend_eof));
        chk(pair_valid == 1'b0, "R4", {pend_lbl, " pair pulse width"}, int'(pair_valid), 0);
        pend = 1'b0;
      end else if (pair_valid) begin
        if (qa.size() == 0) begin
          chk(1'b0, "R4", "pair without accepted bit", 1, 0);
        end else begin
          bit ea, eb, ee;
          string l;
          ea = qa.pop_front();
          eb = qb.pop_front();
          ee = qe.pop_front();
          l  = ql.pop_front();
          chk(pair_a == ea, "R2", {l, " first coded bit"}, int'(pair_a), int'(ea));
          chk(pair_b == eb, "R3", {l, " second coded bit"}, int'(pair_b), int'(eb));
          chk(pair_eof == ee, "R7", {l, " pair end flag"}, int'(pair_eof), int'(ee));
          chk(ser_valid == 1'b1 && ser_bit == ea && ser_eof == 1'b0, "R5",
              {l, " first serial bit"}, int'(ser_bit), int'(ea));
          pend = 1'b1;
          pend_bit = eb;
          pend_eof = ee;
          pend_lbl = l;
        end
      end else begin
        chk(ser_valid == 1'b0, "R5", "serial idle without pair", int'(ser_valid), 0);
      end
    end
  end

  task automatic send_bit(input bit b, input string lbl, input bit junk);
    chk(in_ready == 1'b1, "R6", "ready before send", int'(in_ready), 1);
    model_step(b, 1'b0, lbl);
    in_valid = 1'b1;
    in_bit = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R6", "ready low after accept", int'(in_ready), 0);
    if (junk) begin
      in_valid = 1'b1;  // R10: stray request while busy
      in_bit = ~b;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b1, "R6", "ready back for next bit", int'(in_ready), 1);
  endtask

  task automatic do_flush(input bit with_data, input string lbl);
    int lowc;
    chk(in_ready == 1'b1, "R7", "ready before flush", int'(in_ready), 1);
    model_step(1'b0, 1'b0, lbl);
    model_step(1'b0, 1'b1, lbl);
    flush = 1'b1;
    if (with_data) begin
      in_valid = 1'b1;  // R9: data colliding with flush
      in_bit = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0;
    lowc = 0;
    while (!in_ready && lowc < 20) begin
      in_valid = 1'b1;  // R10: ignored during tail
      in_bit = 1'b1;
      lowc++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(lowc == 3, "R7", "ready low cycles during tail", lowc, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pair_valid == 1'b0 && ser_valid == 1'b0, "R1", "valids in reset", int'(pair_valid | ser_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    chk(pair_eof == 1'b0 && ser_eof == 1'b0, "R1", "end flags after reset", int'(pair_eof | ser_eof), 0);
    repeat (2) @(negedge clk);

    // R11 impulse from the zero state (first pair also covers R1)
    send_bit(1'b1, "R1", 1'b0);
    send_bit(1'b0, "R11", 1'b0);
    send_bit(1'b0, "R11", 1'b0);
    send_bit(1'b0, "R11", 1'b0);
    repeat (3) @(negedge clk);

    // Mixed pattern with stray requests while busy
    send_bit(1'b1, "R10", 1'b1);
    send_bit(1'b0, "R10", 1'b1);
    send_bit(1'b1, "R10", 1'b0);
    send_bit(1'b1, "R10", 1'b1);
    @(negedge clk);
    send_bit(1'b0, "R2", 1'b0);
    send_bit(1'b1, "R3", 1'b0);
    do_flush(1'b0, "R7");
    chk(m1 == 1'b0 && m2 == 1'b0, "R8", "model cleared by tail", int'({m1, m2}), 0);

    // R8: fresh frame after termination
    send_bit(1'b1, "R8", 1'b0);
    send_bit(1'b1, "R8", 1'b0);
    do_flush(1'b1, "R9");

    // All ones, then alternating
    for (int i = 0; i < 6; i++) send_bit(1'b1, "R2", 1'b0);
    for (int i = 0; i < 6; i++) send_bit(i[0], "R3", i == 2);
    do_flush(1'b0, "R7");

    repeat (4) @(negedge clk);
    chk(qa.size() == 0, "R4", "all predicted pairs seen", qa.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule